// File: doc/BRIEF.md
# Two-Phase Interleaved Digital PWM

This block is a counter-driven pulse-width modulator for a two-phase power stage. One free-running period counter serves both switches. Phase A begins its on-time at count 0, and phase B begins its on-time half a period later. Both phases take the same duty command, so the two switches share the load while running 180 degrees apart.

A duty word arrives with a load strobe and goes into a holding register. Each phase copies the held word into its own working register only when its own period begins. A pulse that is already under way therefore keeps the length it started with.

The block also emits a strobe on the first count of every period. It emits a sample trigger for the current converter at evenly spaced counts that stay locked to the period. The defaults are a 50 MHz clock, 1600 counts per period (32 us), an 11-bit duty word and 16 samples per period.

Top module: `interleaved_dpwm`

## Requirements
- R1: While `rst_n` is low, both gates, `period_start` and `sample_trig` are low. The first `period_start` appears in the first cycle after the first rising clock edge that follows release.
- R2: The counter runs from 0 to PERIOD-1 (1599) and then wraps. `period_start` is high exactly in the cycles where the count is 0, which is once every PERIOD cycles.
- R3: The duty word is an unsigned number of clock cycles. `gate_a` is high while the count is below the duty word that phase A currently uses. It goes high only at count 0.
- R4: Phase B has a local count equal to (count + PERIOD/2) mod PERIOD, so its on-time starts at count 800. `gate_b` is high while this local count is below the duty word that phase B currently uses.
- R5: A duty word of 0 keeps a gate low for its whole period. A duty word of PERIOD or more (1600 up to 2047) keeps the gate high for every cycle of the period. A duty word of PERIOD-1 gives a gate that is high for PERIOD-1 cycles.
- R6: On each rising clock edge where `duty_load` is high, `duty_cmd` is captured into the holding register. A phase adopts the held value only on the clock edge where its own local count wraps from PERIOD-1 to 0. A load made in the middle of a period does not lengthen or shorten the pulse that is running.
- R7: A load that coincides with a phase's wrap edge (count 1599 for A, count 799 for B) applies to the period that starts on that edge. The value held before the load does not.
- R8: `sample_trig` is high in the cycles where the count is a multiple of PERIOD/SAMPLES (100). This gives 16 triggers per period, and one of them always coincides with `period_start`.
- R9: While `duty_load` is low, changes on `duty_cmd` have no effect on either gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | 11 | Duty word, in clock cycles of on-time |
| duty_load | input | 1 | Captures `duty_cmd` into the holding register |
| gate_a | output | 1 | Gate drive of the phase that starts at count 0 |
| gate_b | output | 1 | Gate drive of the phase that starts at count 800 |
| period_start | output | 1 | High in the first cycle of each period |
| sample_trig | output | 1 | Current-sample trigger, 16 per period |

## Verification
A new duty load can land on the same edge where a phase hands over to its next period. In that case the holding register and the phase's working register change together. The bench drives `duty_load` in the last cycle of phase A's period (count 1599), and separately in the last cycle of phase B's period (count 799). In both cases the held value differs from the new one beforehand. The bench then measures the on-time of the following pulse and expects the new value, not the old held value. It also checks that loads made a few hundred counts into a pulse leave that pulse's falling edge where it was.

// File: rtl/ipwm_pkg.sv
package ipwm_pkg;

  // Folds a count shifted by 'shift' back into the range 0..per-1.
  // Valid when c < per and shift <= per.
  function automatic int unsigned fold(input int unsigned c,
                                       input int unsigned shift,
                                       input int unsigned per);
    int unsigned s;
    s = c + shift;
    return (s >= per) ? (s - per) : s;
  endfunction

  // Count at which phase p begins its on-time.
  function automatic int unsigned phase_origin(input int unsigned p,
                                               input int unsigned phases,
                                               input int unsigned per);
    return (p * per) / phases;
  endfunction

  // A gate is on while its local count is below the duty word.
  function automatic bit pulse_on(input int unsigned local_cnt,
                                  input int unsigned duty);
    return local_cnt < duty;
  endfunction

endpackage

// File: rtl/ipwm_counter.sv
module ipwm_counter #(
  parameter int unsigned PERIOD  = 1600,
  parameter int unsigned SAMPLES = 16,
  parameter int unsigned CNT_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             period_start,
  output logic             sample_trig
);
  localparam int unsigned SPACING = PERIOD / SAMPLES;
  localparam int unsigned SUB_W   = (SPACING > 1) ? $clog2(SPACING) : 1;

  logic [SUB_W-1:0] sub;
  logic             at_end;
  logic             sub_end;

  assign at_end  = (cnt == CNT_W'(PERIOD - 1));
  assign sub_end = (sub == SUB_W'(SPACING - 1));

  // Reset parks the counter on its last count, so the release edge opens a period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CNT_W'(PERIOD - 1);
    end else begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end

  // The sub-period counter is forced back to zero at every wrap, so triggers stay locked to the period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub <= SUB_W'(SPACING - 1);
    end else begin
      sub <= (at_end || sub_end) ? '0 : sub + 1'b1;
    end
  end

  assign period_start = (cnt == '0);
  assign sample_trig  = (sub == '0);
endmodule

// File: rtl/ipwm_shadow.sv
module ipwm_shadow #(
  parameter int unsigned DUTY_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic              duty_load,
  output logic [DUTY_W-1:0] next_duty
);
  logic [DUTY_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (duty_load) begin
      held <= duty_cmd;
    end
  end

  // A load on the hand-over edge is forwarded, so it reaches the period that opens on that edge.
  assign next_duty = duty_load ? duty_cmd : held;
endmodule

// File: rtl/ipwm_phase.sv
module ipwm_phase #(
  parameter int unsigned PERIOD = 1600,
  parameter int unsigned ORIGIN = 0,
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned DUTY_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DUTY_W-1:0] next_duty,
  output logic              gate,
  output logic              phase_start
);
  localparam int unsigned SHIFT = PERIOD - ORIGIN;

  logic [CNT_W-1:0]  local_cnt;
  logic [DUTY_W-1:0] active;
  logic              handover;

  assign local_cnt   = CNT_W'(ipwm_pkg::fold(32'(cnt), SHIFT, PERIOD));
  assign handover    = (local_cnt == CNT_W'(PERIOD - 1));
  assign phase_start = (local_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else if (handover) begin
      active <= next_duty;
    end
  end

  assign gate = ipwm_pkg::pulse_on(32'(local_cnt), 32'(active));
endmodule

// File: rtl/interleaved_dpwm.sv
module interleaved_dpwm #(
  parameter int unsigned PERIOD  = 1600,
  parameter int unsigned SAMPLES = 16,
  parameter int unsigned DUTY_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic              duty_load,
  output logic              gate_a,
  output logic              gate_b,
  output logic              period_start,
  output logic              sample_trig
);
  localparam int unsigned PHASES = 2;
  localparam int unsigned CNT_W  = $clog2(PERIOD);

  logic [CNT_W-1:0]  cnt;
  logic [DUTY_W-1:0] next_duty;
  logic [PHASES-1:0] gate;
  logic [PHASES-1:0] phase_start;

  ipwm_counter #(
    .PERIOD (PERIOD),
    .SAMPLES(SAMPLES),
    .CNT_W  (CNT_W)
  ) i_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt         (cnt),
    .period_start(period_start),
    .sample_trig (sample_trig)
  );

  ipwm_shadow #(
    .DUTY_W(DUTY_W)
  ) i_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .duty_cmd (duty_cmd),
    .duty_load(duty_load),
    .next_duty(next_duty)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    ipwm_phase #(
      .PERIOD(PERIOD),
      .ORIGIN(ipwm_pkg::phase_origin(p, PHASES, PERIOD)),
      .CNT_W (CNT_W),
      .DUTY_W(DUTY_W)
    ) i_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt        (cnt),
      .next_duty  (next_duty),
      .gate       (gate[p]),
      .phase_start(phase_start[p])
    );
  end

  assign gate_a = gate[0];
  assign gate_b = gate[1];
endmodule

// File: rtl/ipwm_checker.sv
module ipwm_checker #(
  parameter int unsigned PERIOD  = 1600,
  parameter int unsigned SAMPLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       gate_a,
  input logic       gate_b,
  input logic       period_start,
  input logic       sample_trig,
  input logic [1:0] phase_start
);
  localparam int unsigned SPACING = PERIOD / SAMPLES;

  logic [31:0] gap_p;
  logic [31:0] gap_s;
  logic        seen_p;
  logic        seen_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_p  <= '0;
      seen_p <= 1'b0;
    end else if (period_start) begin
      gap_p  <= '0;
      seen_p <= 1'b1;
    end else begin
      gap_p <= gap_p + 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_s  <= '0;
      seen_s <= 1'b0;
    end else if (sample_trig) begin
      gap_s  <= '0;
      seen_s <= 1'b1;
    end else begin
      gap_s <= gap_s + 1;
    end
  end

  assert_period_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && seen_p) |-> (gap_p == 32'(PERIOD - 1)));

  assert_trig_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_trig && seen_s) |-> (gap_s == 32'(SPACING - 1)));

  assert_trig_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> sample_trig);

  assert_a_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_a) |-> period_start);

  assert_b_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_b) |-> phase_start[1]);

  assert_b_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_start[0] |-> (period_start && !phase_start[1]));
endmodule

bind interleaved_dpwm ipwm_checker #(
  .PERIOD (PERIOD),
  .SAMPLES(SAMPLES)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_a      (gate_a),
  .gate_b      (gate_b),
  .period_start(period_start),
  .sample_trig (sample_trig),
  .phase_start (phase_start)
);

// File: tb/test_interleaved_dpwm.sv
`timescale 1ns/1ps
module test_interleaved_dpwm;
  localparam int PER  = 1600;
  localparam int HALF = 800;
  localparam int SPC  = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] duty_cmd = '0;
  logic        duty_load = 1'b0;
  logic        gate_a, gate_b, period_start, sample_trig;

  int total = 0;
  int bad   = 0;
  bit mon_en = 1'b0;

  int m_cnt = PER - 1;
  int m_sh  = 0;
  int m_a   = 0;
  int m_b   = 0;

  always #2.5 clk = ~clk;

  interleaved_dpwm i_interleaved_dpwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .duty_cmd    (duty_cmd),
    .duty_load   (duty_load),
    .gate_a      (gate_a),
    .gate_b      (gate_b),
    .period_start(period_start),
    .sample_trig (sample_trig)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural expectation built from the requirements: count, held word, per-phase words.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= PER - 1; m_sh <= 0; m_a <= 0; m_b <= 0;
    end else begin
      if (m_cnt == PER - 1)  m_a <= duty_load ? int'(duty_cmd) : m_sh;
      if (m_cnt == HALF - 1) m_b <= duty_load ? int'(duty_cmd) : m_sh;
      if (duty_load) m_sh <= int'(duty_cmd);
      m_cnt <= (m_cnt == PER - 1) ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      int lb;
      bit ea, eb, ep, es;
      lb = (m_cnt >= HALF) ? m_cnt - HALF : m_cnt + HALF;
      ea = (m_cnt < m_a);
      eb = (lb < m_b);
      ep = (m_cnt == 0);
      es = ((m_cnt % SPC) == 0);
      chk(gate_a == ea, "R3 gate_a per cycle", gate_a, ea);
      chk(gate_b == eb, "R4 gate_b per cycle", gate_b, eb);
      chk(period_start == ep, "R2 period_start per cycle", period_start, ep);
      chk(sample_trig == es, "R8 sample_trig per cycle", sample_trig, es);
    end
  end

  task automatic wait_cnt(input int v);
    while (m_cnt != v) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic load(input int v);
    duty_cmd = 11'(v); duty_load = 1'b1;
    @(posedge clk); #1;
    duty_load = 1'b0;
  endtask

  task automatic measure(input int start, input bit use_b, output int width, output int trigs);
    width = 0; trigs = 0;
    wait_cnt(start);
    repeat (PER) begin
      @(negedge clk);
      if (use_b ? gate_b : gate_a) width++;
      if (sample_trig) trigs++;
    end
  endtask

  task automatic t_reset;
    repeat (3) begin
      @(negedge clk);
      chk(!gate_a && !gate_b, "R1 gates low in reset", int'({gate_a, gate_b}), 0);
      chk(!period_start && !sample_trig, "R1 strobes low in reset",
          int'({period_start, sample_trig}), 0);
    end
    @(posedge clk); #1; rst_n = 1'b1; mon_en = 1'b1;
    @(negedge clk);
    chk(period_start == 1'b0, "R1 no strobe before first edge", period_start, 0);
    @(negedge clk);
    chk(period_start == 1'b1, "R1 first period_start after release", period_start, 1);
  endtask

  task automatic t_duty(input int v, input string tag);
    int w, tr;
    wait_cnt(200); load(v);
    measure(0, 1'b0, w, tr);
    chk(w == ((v >= PER) ? PER : v), {tag, " gate_a width"}, w, (v >= PER) ? PER : v);
    chk(tr == 16, "R8 triggers per period", tr, 16);
    measure(HALF, 1'b1, w, tr);
    chk(w == ((v >= PER) ? PER : v), {tag, " gate_b width"}, w, (v >= PER) ? PER : v);
  endtask

  task automatic t_midperiod;
    int w, tr;
    wait_cnt(100); load(500);
    wait_cnt(0); @(posedge clk); #1;
    wait_cnt(300); load(900);
    wait_cnt(600); #1;
    chk(gate_a == 1'b0, "R6 running A pulse not lengthened", gate_a, 0);
    measure(0, 1'b0, w, tr);
    chk(w == 900, "R6 A adopts load next period", w, 900);
    wait_cnt(1000); load(100);
    wait_cnt(1500); #1;
    chk(gate_b == 1'b1, "R6 running B pulse not shortened", gate_b, 1);
    measure(HALF, 1'b1, w, tr);
    chk(w == 100, "R6 B adopts load next period", w, 100);
  endtask

  task automatic t_ignore;
    int w, tr;
    wait_cnt(200); load(700);
    @(posedge clk); #1;
    duty_cmd = 11'd1234;
    measure(0, 1'b0, w, tr);
    chk(w == 700, "R9 duty_cmd without load ignored A", w, 700);
    measure(HALF, 1'b1, w, tr);
    chk(w == 700, "R9 duty_cmd without load ignored B", w, 700);
  endtask

  task automatic t_collide;
    int w, tr;
    wait_cnt(200); load(300);
    wait_cnt(PER - 1); load(1200);
    measure(0, 1'b0, w, tr);
    chk(w == 1200, "R7 load on A hand-over edge", w, 1200);
    wait_cnt(200); load(400);
    wait_cnt(HALF - 1); load(1000);
    measure(HALF, 1'b1, w, tr);
    chk(w == 1000, "R7 load on B hand-over edge", w, 1000);
  endtask

  initial begin
    t_reset();
    t_duty(500, "R3 R4 mid duty");
    t_duty(100, "R3 low duty");
    t_duty(1500, "R4 high duty");
    t_duty(0, "R5 zero duty");
    t_duty(2047, "R5 max word");
    t_duty(1600, "R5 full period");
    t_duty(1599, "R5 one short");
    t_midperiod();
    t_ignore();
    t_collide();
    #10;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule